// File: doc/BRIEF.md
# Two-Port Memory with Same-Address Collision Arbitration

This block is a synchronous two-port word memory. A left port and a right port each have their own enable, write strobe, address, write data and read data. Both ports can read or write in the same cycle. Trouble arises only when both ports select the same word at once. Dedicated logic detects that case and lets one port go ahead. It flags the other port with an active-low busy signal and drops any write that port attempts in that cycle.

A mode pin picks the role of the busy pins. In arbitrating mode, the block decides the loser itself and drives a busy output on each port. In follower mode, the internal decision is switched off and the busy outputs stay high. Each port's busy input then acts only as a write-inhibit. This lets several memories placed side by side obey one arbitrating device, so all slices of a wide word lose together. The address width is a parameter. The default is a 1K-word instance, and an 8K-word build uses `ADDR_W = 13`.

Top module: `dpr_arb_ram`

## Requirements
- R1: In arbitrating mode (`master_mode = 1`), a collision means both enables are high with equal addresses. During a collision exactly one of `l_busy_n_o` and `r_busy_n_o` is low. Outside a collision both are high.
- R2: When a collision starts and neither port was on that address in the previous cycle, the left port wins, so `r_busy_n_o = 0` and `l_busy_n_o = 1`.
- R3: When a collision starts and only the right port was enabled on that address in the previous cycle, the right port keeps priority and `l_busy_n_o = 0`.
- R4: While a collision continues on the same address from one cycle to the next, the winning port does not change.
- R5: The write strobes play no part in choosing the loser. Read/read, read/write and write/write collisions pick the same loser.
- R6: A write by the losing port does not change memory. The winning port's write in the same cycle is stored.
- R7: Read data is registered. `x_rdata` shows the word at the address presented in the previous enabled cycle, as stored before that cycle's writes. A write is visible to a read on either port issued in a later cycle.
- R8: A port flagged busy still gets read data, which holds the currently stored word.
- R9: In follower mode (`master_mode = 0`), both busy outputs are held high whatever the addresses. A low `x_busy_n_i` blocks that port's writes, and a high one lets them through.
- R10: In arbitrating mode the busy inputs are ignored. A write with `x_busy_n_i = 0` and no collision is stored.
- R11: Accesses by both ports to different addresses in the same cycle both complete, with no busy flag.
- R12: During and right after reset, both read data outputs are zero and both busy outputs are high.
- R13: Busy is combinational. It clears in the first cycle in which the collision is no longer presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = arbitrate locally, 0 = follow external busy inputs |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port registered read data |
| l_busy_n_i | input | 1 | Left write-inhibit, active low, used in follower mode |
| l_busy_n_o | output | 1 | Left busy flag, active low, driven in arbitrating mode |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port registered read data |
| r_busy_n_i | input | 1 | Right write-inhibit, active low, used in follower mode |
| r_busy_n_o | output | 1 | Right busy flag, active low, driven in arbitrating mode |

## Verification
The priority properties assume the inputs come out of reset quiet, and they only judge cycles whose previous cycle was also out of reset. The stimulus therefore holds both enables low through reset. It also puts an idle cycle between scenarios, so each scenario starts from a known previous-cycle history. The bench changes inputs only on the falling edge and never sends two unblocked writes to one word in follower mode, because the stored result of that case is not defined by the requirements.

// File: rtl/dpr_arb_pkg.sv
package dpr_arb_pkg;

  typedef enum logic {
    PORT_L = 1'b0,
    PORT_R = 1'b1
  } port_e;

  // True when both sides are enabled on one word.
  function automatic logic same_word(input logic ce_a, input logic ce_b,
                                     input logic [31:0] a, input logic [31:0] b);
    return ce_a && ce_b && (a == b);
  endfunction

  // Priority choice: a continuing collision keeps its winner; a lone
  // incumbent on the right keeps the word; every other case favours left.
  function automatic port_e pick_winner(input logic hold, input port_e held,
                                        input logic l_was, input logic r_was);
    if (hold) return held;
    if (r_was && !l_was) return PORT_R;
    return PORT_L;
  endfunction

endpackage

// File: rtl/dpr_collide_arb.sv
module dpr_collide_arb
  import dpr_arb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_en,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              coll_now,
  output logic              lose_l,
  output logic              lose_r
);

  logic              l_ce_q, r_ce_q, coll_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q, coll_addr_q;
  port_e             win_q, win;
  logic              l_was, r_was, hold;

  assign coll_now = arb_en && same_word(l_ce, r_ce, 32'(l_addr), 32'(r_addr));
  assign l_was    = l_ce_q && (l_addr_q == l_addr);
  assign r_was    = r_ce_q && (r_addr_q == l_addr);
  assign hold     = coll_q && (coll_addr_q == l_addr);
  assign win      = pick_winner(hold, win_q, l_was, r_was);
  assign lose_l   = coll_now && (win == PORT_R);
  assign lose_r   = coll_now && (win == PORT_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_ce_q      <= 1'b0;
      r_ce_q      <= 1'b0;
      coll_q      <= 1'b0;
      l_addr_q    <= '0;
      r_addr_q    <= '0;
      coll_addr_q <= '0;
      win_q       <= PORT_L;
    end else begin
      l_ce_q      <= l_ce;
      r_ce_q      <= r_ce;
      l_addr_q    <= l_addr;
      r_addr_q    <= r_addr;
      coll_q      <= coll_now;
      coll_addr_q <= l_addr;
      win_q       <= win;
    end
  end

  // R2: fresh collision with no incumbent goes to the left port
  p_left_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && coll_now
     && !($past(l_ce) && $past(l_addr) == l_addr)
     && !($past(r_ce) && $past(r_addr) == l_addr)) |-> (lose_r && !lose_l));

  // R3: lone right incumbent keeps the word
  p_incumbent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && coll_now && !$past(coll_now)
     && $past(r_ce) && $past(r_addr) == l_addr
     && !($past(l_ce) && $past(l_addr) == l_addr)) |-> (lose_l && !lose_r));

  // R4: winner stays fixed across a continuing collision
  p_hold_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && coll_now && $past(coll_now) && $past(l_addr) == l_addr)
      |-> (lose_l == $past(lose_l)));

endmodule

// File: rtl/dpr_port_gate.sv
module dpr_port_gate (
  input  logic master_mode,
  input  logic ce,
  input  logic we,
  input  logic arb_lose,
  input  logic busy_n_i,
  output logic busy_n_o,
  output logic wr_en
);

  logic inhibit;

  assign busy_n_o = master_mode ? !arb_lose : 1'b1;
  assign inhibit  = master_mode ? arb_lose : !busy_n_i;
  assign wr_en    = ce && we && !inhibit;

endmodule

// File: rtl/dpr_storage.sv
module dpr_storage #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_ce,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_ce,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_ce) a_rdata <= mem[a_addr];
      if (b_ce) b_rdata <= mem[b_addr];
    end
  end

endmodule

// File: rtl/dpr_arb_ram.sv
module dpr_arb_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_n_i,
  output logic              l_busy_n_o,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_n_i,
  output logic              r_busy_n_o
);

  localparam int NPORT = 2;

  logic             coll_now, lose_l, lose_r;
  logic [NPORT-1:0] ce_v, we_v, lose_v, bsyi_v, bsyo_v, wr_v;

  dpr_collide_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .arb_en   (master_mode),
    .l_ce     (l_ce),
    .l_addr   (l_addr),
    .r_ce     (r_ce),
    .r_addr   (r_addr),
    .coll_now (coll_now),
    .lose_l   (lose_l),
    .lose_r   (lose_r)
  );

  assign ce_v   = {r_ce, l_ce};
  assign we_v   = {r_we, l_we};
  assign lose_v = {lose_r, lose_l};
  assign bsyi_v = {r_busy_n_i, l_busy_n_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port_gate u_gate (
      .master_mode (master_mode),
      .ce          (ce_v[p]),
      .we          (we_v[p]),
      .arb_lose    (lose_v[p]),
      .busy_n_i    (bsyi_v[p]),
      .busy_n_o    (bsyo_v[p]),
      .wr_en       (wr_v[p])
    );
  end

  assign l_busy_n_o = bsyo_v[0];
  assign r_busy_n_o = bsyo_v[1];

  dpr_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_ce    (l_ce),
    .a_wr    (wr_v[0]),
    .a_addr  (l_addr),
    .a_wdata (l_wdata),
    .a_rdata (l_rdata),
    .b_ce    (r_ce),
    .b_wr    (wr_v[1]),
    .b_addr  (r_addr),
    .b_wdata (r_wdata),
    .b_rdata (r_rdata)
  );

  // R1: exactly one busy port during a same-word collision
  p_one_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && l_ce && r_ce && l_addr == r_addr)
      |-> ($countones({!l_busy_n_o, !r_busy_n_o}) == 1));

  // R1, R13: no busy flag without a collision
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !(l_ce && r_ce && l_addr == r_addr))
      |-> (l_busy_n_o && r_busy_n_o));

  // R6: a busy-flagged port never reaches the storage write strobe
  p_block_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !l_busy_n_o) |-> !wr_v[0]);
  p_block_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !r_busy_n_o) |-> !wr_v[1]);

  // R9: follower mode keeps busy outputs idle and honours the inhibit input
  p_slave_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_n_o && r_busy_n_o && !coll_now));
  p_slave_inh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !l_busy_n_i) |-> !wr_v[0]);

  // R10: arbitrating mode ignores the inhibit input
  p_master_ign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !l_busy_n_i && l_ce && l_we && l_busy_n_o) |-> wr_v[0]);

endmodule

// File: tb/dpr_arb_ram_tb.sv
module dpr_arb_ram_tb_top;

  localparam int AW = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          master_mode = 1'b1;
  logic          l_ce = 1'b0, l_we = 1'b0, l_busy_n_i = 1'b1;
  logic          r_ce = 1'b0, r_we = 1'b0, r_busy_n_i = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic          l_busy_n_o, r_busy_n_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dpr_arb_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_n_i(l_busy_n_i), .l_busy_n_o(l_busy_n_o),
    .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_n_i(r_busy_n_i), .r_busy_n_o(r_busy_n_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive both ports at the falling edge, then let combinational busy settle.
  task automatic step(input logic lce, input logic lwe, input logic [AW-1:0] la,
                      input logic [DW-1:0] lw, input logic rce, input logic rwe,
                      input logic [AW-1:0] ra, input logic [DW-1:0] rw);
    l_ce = lce; l_we = lwe; l_addr = la; l_wdata = lw;
    r_ce = rce; r_we = rwe; r_addr = ra; r_wdata = rw;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
    tick();
  endtask

  task automatic busy_pair(input string req, input logic le, input logic re);
    chk(req, {31'd0, l_busy_n_o}, {31'd0, le});
    chk(req, {31'd0, r_busy_n_o}, {31'd0, re});
  endtask

  task automatic t_reset();
    chk("R12 l_rdata", {24'd0, l_rdata}, 32'd0);
    chk("R12 r_rdata", {24'd0, r_rdata}, 32'd0);
    busy_pair("R12 busy", 1'b1, 1'b1);
  endtask

  task automatic t_independent();
    step(1, 1, 10'd16, 8'h11, 1, 1, 10'd17, 8'h22);
    busy_pair("R11 no busy", 1'b1, 1'b1);
    tick();
    step(1, 0, 10'd17, 8'h00, 1, 0, 10'd16, 8'h00);
    tick();
    chk("R11 l reads right write", {24'd0, l_rdata}, 32'h22);
    chk("R7 r reads left write", {24'd0, r_rdata}, 32'h11);
    idle();
  endtask

  task automatic t_onset_ww();
    step(1, 1, 10'd32, 8'h33, 1, 1, 10'd32, 8'h44);
    busy_pair("R2 onset right busy", 1'b1, 1'b0);
    tick();
    idle();
    step(1, 0, 10'd32, 8'h00, 0, 0, '0, '0);
    tick();
    chk("R6 winner stored", {24'd0, l_rdata}, 32'h33);
    idle();
  endtask

  task automatic t_onset_rw();
    step(1, 1, 10'd48, 8'h5a, 0, 0, '0, '0);
    tick();
    idle();
    step(1, 0, 10'd48, 8'h00, 1, 1, 10'd48, 8'ha5);
    busy_pair("R5 read/write same loser", 1'b1, 1'b0);
    tick();
    chk("R7 read-first", {24'd0, l_rdata}, 32'h5a);
    idle();
    step(0, 0, '0, '0, 1, 0, 10'd48, 8'h00);
    tick();
    chk("R6 blocked write", {24'd0, r_rdata}, 32'h5a);
    idle();
  endtask

  task automatic t_incumbent();
    step(1, 1, 10'd64, 8'h55, 0, 0, '0, '0);
    tick();
    idle();
    step(0, 0, '0, '0, 1, 0, 10'd64, 8'h00);
    busy_pair("R3 lone access", 1'b1, 1'b1);
    tick();
    step(1, 1, 10'd64, 8'h66, 1, 0, 10'd64, 8'h00);
    busy_pair("R3 incumbent right", 1'b0, 1'b1);
    tick();
    chk("R8 winner read", {24'd0, r_rdata}, 32'h55);
    step(1, 0, 10'd64, 8'h00, 1, 0, 10'd64, 8'h00);
    busy_pair("R4 hold winner", 1'b0, 1'b1);
    tick();
    chk("R8 busy port read", {24'd0, l_rdata}, 32'h55);
    step(1, 0, 10'd64, 8'h00, 0, 0, '0, '0);
    busy_pair("R13 release", 1'b1, 1'b1);
    tick();
    chk("R6 incumbent kept data", {24'd0, l_rdata}, 32'h55);
    idle();
  endtask

  task automatic t_hold_left();
    step(1, 0, 10'd80, 8'h00, 1, 0, 10'd80, 8'h00);
    busy_pair("R5 read/read loser", 1'b1, 1'b0);
    tick();
    step(1, 1, 10'd80, 8'h4c, 1, 1, 10'd80, 8'hc4);
    busy_pair("R4 hold left", 1'b1, 1'b0);
    tick();
    step(1, 0, 10'd80, 8'h00, 1, 1, 10'd81, 8'h81);
    busy_pair("R13 moved away", 1'b1, 1'b1);
    tick();
    idle();
    step(1, 0, 10'd80, 8'h00, 1, 0, 10'd81, 8'h00);
    tick();
    chk("R6 left write kept", {24'd0, l_rdata}, 32'h4c);
    chk("R13 write after release", {24'd0, r_rdata}, 32'h81);
    idle();
  endtask

  task automatic t_slave();
    master_mode = 1'b0;
    step(1, 1, 10'd96, 8'h71, 1, 1, 10'd97, 8'h82);
    busy_pair("R9 slave outputs idle", 1'b1, 1'b1);
    tick();
    l_busy_n_i = 1'b0;
    step(1, 1, 10'd96, 8'hee, 1, 1, 10'd97, 8'h28);
    tick();
    l_busy_n_i = 1'b1;
    idle();
    step(1, 0, 10'd96, 8'h00, 1, 0, 10'd96, 8'h00);
    busy_pair("R9 slave same word idle", 1'b1, 1'b1);
    tick();
    chk("R9 inhibited write", {24'd0, l_rdata}, 32'h71);
    idle();
    step(0, 0, '0, '0, 1, 0, 10'd97, 8'h00);
    tick();
    chk("R9 allowed write", {24'd0, r_rdata}, 32'h28);
    idle();
    master_mode = 1'b1;
    idle();
  endtask

  task automatic t_master_ignores();
    l_busy_n_i = 1'b0;
    step(1, 1, 10'd112, 8'h99, 0, 0, '0, '0);
    busy_pair("R10 no busy", 1'b1, 1'b1);
    tick();
    l_busy_n_i = 1'b1;
    idle();
    step(0, 0, '0, '0, 1, 0, 10'd112, 8'h00);
    tick();
    chk("R10 write stored", {24'd0, r_rdata}, 32'h99);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_independent();
    t_onset_ww();
    t_onset_rw();
    t_incumbent();
    t_hold_left();
    t_slave();
    t_master_ignores();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule